// File: doc/BRIEF.md
# Quad-lane fast read controller

This block is the host side of a four-lane serial flash read. Given a request with a 24-bit address, an 8-bit mode value, a byte count and a speed select, it pulls chip select low. It sends the fast quad read opcode on lane 0 only. It then sends the address and the mode value four bits per serial clock on all four lanes. After that it releases the lanes for a number of idle clocks that depends on the speed select, and gathers the returned nibbles into bytes.

The bytes leave on a valid/ready stream. The serial clock runs at half the system clock. When the stream sink stalls at a byte boundary, the serial clock is held low, so the device cannot move ahead and no byte is lost. After the last requested byte is captured, chip select rises and the controller is ready for the next request.

Top module: `qfr_top`

## Requirements
- R1: While no transfer is in progress, cs_n is 1, sclk is 0, lane_oe is 0000, out_valid starts at 0 after reset, and req_ready is 1.
- R2: A transfer begins with eight serial clocks carrying the opcode 8'hEB on lane_out[0], most significant bit first, with lane_oe = 0001.
- R3: The next eight serial clocks carry {address[23:0], mode[7:0]} as nibbles, most significant nibble first, with lane_out[3] holding the highest bit of each nibble, lane_oe = 1111, and the mode value taken unchanged from the request.
- R4: Once the mode nibbles are sent, lane_oe is 0000 until cs_n rises. Data sampling starts after 4 idle serial clocks when req_fast is 0, or after 8 when req_fast is 1.
- R5: Each data byte is made from two serial clocks, high nibble first, with lane_in[3] giving bit 7 (then bit 3) and lane_in[0] giving bit 4 (then bit 0). The byte is presented on out_data.
- R6: A request with count N>0 produces exactly N bytes and 16 + idle + 2N rising serial clock edges, then cs_n returns to 1.
- R7: While out_valid is 1 and out_ready is 0, out_valid and out_data hold. The serial clock stops low before the next byte would complete, so every byte arrives in order.
- R8: A request with count 0 is consumed with no effect: cs_n stays 1, no sclk edge, no output byte.
- R9: Transfers may follow back to back. cs_n is high for at least one cycle between them, and each transfer uses its own address, mode and speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 24 | Start byte address |
| req_mode | input | 8 | Mode value sent after the address |
| req_len | input | LEN_W (8) | Number of bytes to read |
| req_fast | input | 1 | 1 selects the longer idle gap for high clock rates |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | Sink takes the byte |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| lane_oe | output | 4 | Per-lane output enable |
| lane_out | output | 4 | Per-lane outgoing bit |
| lane_in | input | 4 | Per-lane incoming bit |

## Verification
The hardest case to reach is a sink stall that lands exactly when the second nibble of a byte is due while the previous byte is still unread. If the clock is held one edge too late, the device moves ahead and a byte is lost. The bench's device model changes its output only on falling serial clock edges. The directed stall scenarios drop out_ready for long and irregular stretches in the middle of multi-byte reads. Any missed or extra clock then shows up as a byte mismatch or as a wrong total count of rising edges.

// File: rtl/qfr_pkg.sv
package qfr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_DUMMY = 3'd3,
    ST_DATA  = 3'd4,
    ST_DONE  = 3'd5
  } qfr_state_e;

  localparam logic [7:0] QFR_OPCODE   = 8'hEB;
  localparam int         QFR_LANES    = 4;
  localparam int         QFR_CMD_CLKS = 8;
  localparam int         QFR_ADR_CLKS = 8;

endpackage

// File: rtl/qfr_seq.sv
module qfr_seq
  import qfr_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int DUMMY_SLOW = 4,
  parameter int DUMMY_FAST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_fast,
  input  logic             out_full,
  input  logic             out_ready,
  output logic             req_ready,
  output logic             accept,
  output qfr_state_e       state,
  output logic             sclk_hi,
  output logic             fall,
  output logic             nib_lo
);

  localparam int MAXC  = (DUMMY_FAST > QFR_CMD_CLKS) ? DUMMY_FAST : QFR_CMD_CLKS;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(QFR_CMD_CLKS - 1);
  localparam logic [CNT_W-1:0] ADR_LAST  = CNT_W'(QFR_ADR_CLKS - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(DUMMY_SLOW - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(DUMMY_FAST - 1);

  qfr_state_e       st_q, st_d;
  logic             ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             fast_q, fast_d;
  logic             active;
  logic             hold;
  logic [CNT_W-1:0] dummy_last;

  assign active     = (st_q == ST_CMD) || (st_q == ST_ADDR) ||
                      (st_q == ST_DUMMY) || (st_q == ST_DATA);
  assign hold       = (st_q == ST_DATA) && !ph_q && cnt_q[0] && out_full && !out_ready;
  assign fall       = active && ph_q;
  assign accept     = (st_q == ST_IDLE) && req_valid && (req_len != '0);
  assign req_ready  = (st_q == ST_IDLE);
  assign dummy_last = fast_q ? FAST_LAST : SLOW_LAST;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    fast_d = fast_q;
    ph_d   = 1'b0;
    if (active) begin
      ph_d = hold ? ph_q : ~ph_q;
    end
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_CMD;
          cnt_d  = '0;
          left_d = req_len;
          fast_d = req_fast;
        end
      end
      ST_CMD: begin
        if (fall) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CMD_LAST) begin
            st_d  = ST_ADDR;
            cnt_d = '0;
          end
        end
      end
      ST_ADDR: begin
        if (fall) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == ADR_LAST) begin
            st_d  = ST_DUMMY;
            cnt_d = '0;
          end
        end
      end
      ST_DUMMY: begin
        if (fall) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == dummy_last) begin
            st_d  = ST_DATA;
            cnt_d = '0;
          end
        end
      end
      ST_DATA: begin
        if (fall) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q[0]) begin
            left_d = left_q - 1'b1;
            if (left_q == LEN_W'(1)) begin
              st_d = ST_DONE;
            end
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      left_q <= '0;
      fast_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
      fast_q <= fast_d;
    end
  end

  assign state   = st_q;
  assign sclk_hi = ph_q;
  assign nib_lo  = cnt_q[0];

  // R8
  zero_len_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && (req_len == '0)) |=> (state == ST_IDLE));

endmodule

// File: rtl/qfr_tx.sv
module qfr_tx
  import qfr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic [23:0] req_addr,
  input  logic [7:0]  req_mode,
  input  qfr_state_e  state,
  input  logic        fall,
  output logic [3:0]  lane_oe,
  output logic [3:0]  lane_out
);

  localparam int SH_W = 8 + 24 + 8;

  logic [SH_W-1:0]      sh_q, sh_d;
  logic [QFR_LANES-1:0] quad_bits;

  genvar g;
  generate
    for (g = 0; g < QFR_LANES; g++) begin : g_lane_map
      assign quad_bits[g] = sh_q[SH_W-QFR_LANES+g];
    end
  endgenerate

  always_comb begin
    sh_d = sh_q;
    if (accept) begin
      sh_d = {QFR_OPCODE, req_addr, req_mode};
    end else if (fall && (state == ST_CMD)) begin
      sh_d = {sh_q[SH_W-2:0], 1'b0};
    end else if (fall && (state == ST_ADDR)) begin
      sh_d = {sh_q[SH_W-QFR_LANES-1:0], {QFR_LANES{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  always_comb begin
    lane_oe  = 4'b0000;
    lane_out = 4'b0000;
    if (state == ST_CMD) begin
      lane_oe  = 4'b0001;
      lane_out = {3'b000, sh_q[SH_W-1]};
    end else if (state == ST_ADDR) begin
      lane_oe  = 4'b1111;
      lane_out = quad_bits;
    end
  end

  // R2 R3
  lane_oe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe == 4'b0000) || (lane_oe == 4'b0001) || (lane_oe == 4'b1111));

endmodule

// File: rtl/qfr_rx.sv
module qfr_rx
  import qfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  qfr_state_e state,
  input  logic       fall,
  input  logic       nib_lo,
  input  logic [3:0] lane_in,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_valid
);

  logic [3:0] hi_q, hi_d;
  logic [7:0] dat_q, dat_d;
  logic       vld_q, vld_d;
  logic       cap;

  assign cap = fall && (state == ST_DATA);

  always_comb begin
    hi_d  = hi_q;
    dat_d = dat_q;
    vld_d = vld_q;
    if (vld_q && out_ready) begin
      vld_d = 1'b0;
    end
    if (cap && !nib_lo) begin
      hi_d = lane_in;
    end
    if (cap && nib_lo) begin
      dat_d = {hi_q, lane_in};
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      dat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      hi_q  <= hi_d;
      dat_q <= dat_d;
      vld_q <= vld_d;
    end
  end

  assign out_data  = dat_q;
  assign out_valid = vld_q;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/qfr_top.sv
module qfr_top
  import qfr_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int DUMMY_SLOW = 4,
  parameter int DUMMY_FAST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [7:0]       req_mode,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_fast,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             cs_n,
  output logic             sclk,
  output logic [3:0]       lane_oe,
  output logic [3:0]       lane_out,
  input  logic [3:0]       lane_in
);

  qfr_state_e state;
  logic       accept;
  logic       sclk_hi;
  logic       fall;
  logic       nib_lo;

  qfr_seq #(
    .LEN_W      (LEN_W),
    .DUMMY_SLOW (DUMMY_SLOW),
    .DUMMY_FAST (DUMMY_FAST)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_len   (req_len),
    .req_fast  (req_fast),
    .out_full  (out_valid),
    .out_ready (out_ready),
    .req_ready (req_ready),
    .accept    (accept),
    .state     (state),
    .sclk_hi   (sclk_hi),
    .fall      (fall),
    .nib_lo    (nib_lo)
  );

  qfr_tx i_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .req_addr (req_addr),
    .req_mode (req_mode),
    .state    (state),
    .fall     (fall),
    .lane_oe  (lane_oe),
    .lane_out (lane_out)
  );

  qfr_rx i_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .fall      (fall),
    .nib_lo    (nib_lo),
    .lane_in   (lane_in),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  assign cs_n = (state == ST_IDLE) || (state == ST_DONE);
  assign sclk = sclk_hi;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sclk && (lane_oe == 4'b0000)));

  // R4
  lanes_stay_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (lane_oe == 4'b0000)) |=> (cs_n || (lane_oe == 4'b0000)));

endmodule

// File: tb/test_qfr_top.sv
`timescale 1ns/1ps
module test_qfr_top;

  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic [23:0]      req_addr;
  logic [7:0]       req_mode;
  logic [LEN_W-1:0] req_len;
  logic             req_fast;
  logic [7:0]       out_data;
  logic             out_valid;
  logic             out_ready;
  logic             cs_n;
  logic             sclk;
  logic [3:0]       lane_oe;
  logic [3:0]       lane_out;
  logic [3:0]       lane_in;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  qfr_top #(.LEN_W(LEN_W)) i_qfr_top (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_mode (req_mode),
    .req_len (req_len), .req_fast (req_fast),
    .out_data (out_data), .out_valid (out_valid), .out_ready (out_ready),
    .cs_n (cs_n), .sclk (sclk),
    .lane_oe (lane_oe), .lane_out (lane_out), .lane_in (lane_in)
  );

  // Device model state
  logic [23:0] cur_addr = '0;
  logic [7:0]  cur_mode = '0;
  int          exp_dummy = 4;
  int          m_rise = 0;
  logic [7:0]  m_op = '0;
  logic [31:0] m_am = '0;
  int          m_oe_err = 0;
  int          last_rise = 0;
  logic [7:0]  last_op = '0;
  logic [31:0] last_am = '0;
  int          last_oe_err = 0;
  logic [3:0]  m_drive = '0;

  assign lane_in = m_drive;

  function automatic logic [7:0] pat(input int i);
    logic [7:0] v;
    v = cur_addr[7:0] + 8'(i * 29);
    return v ^ cur_mode;
  endfunction

  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      last_rise   = m_rise;
      last_op     = m_op;
      last_am     = m_am;
      last_oe_err = m_oe_err;
      m_rise   = 0;
      m_op     = '0;
      m_am     = '0;
      m_oe_err = 0;
    end else begin
      if (m_rise < 8) begin
        m_op = {m_op[6:0], lane_out[0]};
        if (lane_oe !== 4'b0001) m_oe_err++;
      end else if (m_rise < 16) begin
        m_am = {m_am[27:0], lane_out};
        if (lane_oe !== 4'b1111) m_oe_err++;
      end else begin
        if (lane_oe !== 4'b0000) m_oe_err++;
      end
      m_rise++;
    end
  end

  always @(negedge sclk) begin
    #1;
    if (!cs_n && (m_rise >= 16 + exp_dummy)) begin
      int k;
      logic [7:0] b;
      k = m_rise - 16 - exp_dummy;
      b = pat(k / 2);
      m_drive = ((k % 2) == 0) ? b[7:4] : b[3:0];
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_mode = '0;
    req_len = '0; req_fast = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_reset_state();
    check("R1", "cs_n idle", int'(cs_n), 1);
    check("R1", "sclk idle", int'(sclk), 0);
    check("R1", "lane_oe idle", int'(lane_oe), 0);
    check("R1", "out_valid idle", int'(out_valid), 0);
    check("R1", "req_ready idle", int'(req_ready), 1);
  endtask

  // mode 0: always ready, 1: periodic stall, 2: long stalls
  function automatic logic ready_pat(input int mode, input int cyc);
    if (mode == 0) return 1'b1;
    if (mode == 1) return (cyc % 7) >= 4;
    return (cyc % 53) == 52;
  endfunction

  task automatic run_read(input logic [23:0] a, input logic [7:0] m, input int len,
                          input logic fast, input int rmode, input string tag);
    int got = 0;
    int cyc = 0;
    int bad = 0;
    int hold_bad = 0;
    logic stall_prev = 1'b0;
    logic [7:0] prev_data = '0;
    int expd;
    expd = fast ? 8 : 4;
    cur_addr  = a;
    cur_mode  = m;
    exp_dummy = expd;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_mode = m;
    req_len = LEN_W'(len); req_fast = fast;
    @(negedge clk);
    req_valid = 1'b0;
    while (got < len && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (stall_prev && (!out_valid || out_data != prev_data)) hold_bad++;
      out_ready = ready_pat(rmode, cyc);
      if (out_valid && out_ready) begin
        if (out_data != pat(got)) begin
          bad++;
          $display("FAIL R5 %s byte %0d: actual %0h expected %0h", tag, got, out_data, pat(got));
        end
        got++;
      end
      stall_prev = out_valid && !out_ready;
      prev_data  = out_data;
    end
    @(negedge clk);
    out_ready = 1'b0;
    cyc = 0;
    while (!cs_n && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    n_checks++;
    if (bad != 0) n_fail++;
    check("R6", {tag, " byte count"}, got, len);
    check("R2", {tag, " opcode"}, int'(last_op), 8'hEB);
    check("R3", {tag, " address"}, int'(last_am[31:8]), int'(a));
    check("R3", {tag, " mode"}, int'(last_am[7:0]), int'(m));
    check("R4", {tag, " lane enables"}, last_oe_err, 0);
    check("R6", {tag, " sclk rises"}, last_rise, 16 + expd + 2 * len);
    check("R6", {tag, " cs_n high"}, int'(cs_n), 1);
    check("R7", {tag, " stall hold"}, hold_bad, 0);
    check("R1", {tag, " out drained"}, int'(out_valid), 0);
  endtask

  task automatic test_zero_len();
    int rises = 0;
    int lowcs = 0;
    int vld = 0;
    @(negedge clk);
    req_valid = 1'b1; req_len = '0; req_addr = 24'h123456; req_mode = 8'h11;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!cs_n) lowcs++;
      if (sclk) rises++;
      if (out_valid) vld++;
    end
    check("R8", "cs_n stays high", lowcs, 0);
    check("R8", "no sclk", rises, 0);
    check("R8", "no output", vld, 0);
    check("R8", "ready again", int'(req_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    test_reset_state();
    run_read(24'hA5C30F, 8'h20, 4, 1'b0, 0, "R4 slow");
    run_read(24'h3C1E87, 8'hF0, 5, 1'b1, 0, "R4 fast");
    run_read(24'h00FF10, 8'h5A, 12, 1'b0, 1, "R7 stall");
    run_read(24'hFEDCBA, 8'h01, 9, 1'b1, 2, "R7 long");
    run_read(24'h000001, 8'hA5, 1, 1'b0, 0, "R5 single");
    test_zero_len();
    run_read(24'h800000, 8'h3C, 3, 1'b1, 0, "R9 first");
    run_read(24'h7FFFFF, 8'hC3, 3, 1'b0, 1, "R9 second");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule